// File: doc/BRIEF.md
# Handshaked Byte-Bus Command Slave

This block sits on the device side of an 8-bit parallel link that a microcontroller drives. Every control line is asynchronous to the local clock. The master strobes a start line and then hands over a fixed command packet one byte at a time, using a four-phase request/answer handshake. The packet holds a command code, a register address and a 32-bit data word. The slave performs exactly one access on a single-cycle register-file port. It then returns a fixed reply of a data word followed by a status word, using the same handshake with the direction reversed. While a packet is in flight, an acknowledge (busy) line stays high so that the master knows when the exchange is over.

The data pins are modelled as separate input, output and output-enable signals. The enable is raised only while the master has selected read and a reply byte is on offer, which avoids bus contention. When idle, the slave also answers a bare request with no preceding start, so the master can probe the link without a reset. All inputs from the master pass through a synchroniser chain before use. Sizes, sync depth, read latency of the register file and command codes are all parameters.

Top module: `hsbus_slave`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after it rises, `ans_out`, `busy_out`, `bus_oe` and `rf_stb` are all 0. A reset asserted in the middle of a packet abandons it, and the next full packet is served normally.
- R2: The six command bytes are taken in this order: command code, register address, then data bits 7:0, 15:8, 23:16 and 31:24. Command code 0x02 (write) gives exactly one single-cycle `rf_stb`, with `rf_we`=1, `rf_addr` equal to the address byte and `rf_wdata` equal to the assembled word. The strobe comes while `busy_out` is high and `ans_out` is low.
- R3: During the command phase, `ans_out` rises only after the request is seen high with write selected, and it falls only after the request is seen low.
- R4: Command code 0x01 (read) gives exactly one `rf_stb` with `rf_we`=0 at the address byte. The reply data word is the `rf_rdata` value the port returns one cycle after the strobe, and the reply status is 0.
- R5: The reply is exactly eight bytes: the data word, then the status word, each least significant byte first. For each byte, `ans_out` rises with the byte on `bus_out`, `bus_out` stays stable while `ans_out` is high, and `ans_out` falls after the request is seen high. The next byte is offered only after the request is seen low.
- R6: `bus_oe` is 1 only while read is selected and a reply byte is being offered. It is 0 during the command bytes and during the register access.
- R7: `busy_out` rises within a few cycles of a rising edge on `start_in`, stays high through the last reply byte, and falls once the request of that byte has been seen low. When it rises, `ans_out` is low.
- R8: Any command code other than 0x01 and 0x02 makes no register access. The reply carries data word 0 and status word 1, and the register contents are left unchanged.
- R9: In idle, a request with no start is answered: `ans_out` goes high while the request is high and returns low after it falls. `busy_out` stays low and no strobe occurs.
- R10: A write command replies with its own data word echoed and status 0.
- R11: The whole 8-bit address range is reachable, including addresses 0 and 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset from the master, asynchronous assert |
| start_in | input | 1 | Packet start strobe, a rising edge begins a packet |
| req_in | input | 1 | Request line from the master (master-side handshake) |
| rd_sel_in | input | 1 | Direction select, 1 = master reads, 0 = master writes |
| bus_in | input | 8 | Data pins as seen by the slave |
| bus_out | output | 8 | Reply byte offered to the data pins |
| bus_oe | output | 1 | Drive enable for the data pins |
| ans_out | output | 1 | Answer line to the master (slave-side handshake) |
| busy_out | output | 1 | Acknowledge line, high while a packet is in progress |
| rf_stb | output | 1 | Single-cycle register-file access strobe |
| rf_we | output | 1 | Write enable qualifying `rf_stb` |
| rf_addr | output | 8 | Register address |
| rf_wdata | output | 32 | Register write data |
| rf_rdata | input | 32 | Register read data, valid the cycle after `rf_stb` |

## Verification
The properties assume that the master follows the four-phase protocol. That means it changes the data byte and the direction select only while the request is low and well ahead of raising it, and it holds start high long enough for the synchroniser to see it. The bench master keeps to this. It places data and direction three cycles before each request edge, waits for every answer edge before moving on, and holds start for three cycles. The register file beside the bench answers a strobe with data one cycle later, which matches the default latency the block expects.

// File: rtl/hsbus_pkg.sv
package hsbus_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PROBE,
      ST_CMD_WAIT,
      ST_CMD_HELD,
      ST_ACCESS,
      ST_CAPTURE,
      ST_RSP_SHOW,
      ST_RSP_REL
   } hs_state_t;

endpackage

// File: rtl/hsbus_sync.sv
module hsbus_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/hsbus_engine.sv
module hsbus_engine
   import hsbus_pkg::*;
#(
   parameter int                BYTE_W     = 8,
   parameter int                ADDR_W     = 8,
   parameter int                DATA_W     = 32,
   parameter int                RD_LATENCY = 1,
   parameter logic [BYTE_W-1:0] CMD_READ   = 8'h01,
   parameter logic [BYTE_W-1:0] CMD_WRITE  = 8'h02,
   parameter logic [DATA_W-1:0] BAD_STATUS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_s,
   input  logic              req_s,
   input  logic              rd_s,
   input  logic [BYTE_W-1:0] byte_s,
   output logic [BYTE_W-1:0] bus_out,
   output logic              bus_oe,
   output logic              ans_out,
   output logic              busy_out,
   output logic              rf_stb,
   output logic              rf_we,
   output logic [ADDR_W-1:0] rf_addr,
   output logic [DATA_W-1:0] rf_wdata,
   input  logic [DATA_W-1:0] rf_rdata
);

   localparam int WORD_BYTES = DATA_W / BYTE_W;
   localparam int CMD_BYTES  = WORD_BYTES + 2;
   localparam int RSP_BYTES  = 2 * WORD_BYTES;
   localparam int CNT_W      = $clog2(RSP_BYTES);
   localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_BYTES - 1);
   localparam logic [CNT_W-1:0] RSP_LAST = CNT_W'(RSP_BYTES - 1);
   localparam logic [DATA_W-1:0] ZERO_W  = '0;

   hs_state_t           state;
   logic [CNT_W-1:0]    cnt;
   logic                start_d;
   logic [BYTE_W-1:0]   cmd_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   wdata_q;
   logic [2*DATA_W-1:0] rsp_q;     // status word above data word
   logic                ans_q;
   logic                busy_q;
   logic                start_rise;
   logic                is_rd;
   logic                is_wr;

   assign start_rise = start_s & ~start_d;
   assign is_rd      = (cmd_q == CMD_READ);
   assign is_wr      = (cmd_q == CMD_WRITE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         start_d <= 1'b0;
         cmd_q   <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         rsp_q   <= '0;
         ans_q   <= 1'b0;
         busy_q  <= 1'b0;
      end else begin
         start_d <= start_s;
         case (state)
            ST_IDLE: begin
               if (start_rise) begin
                  busy_q <= 1'b1;
                  cnt    <= '0;
                  state  <= ST_CMD_WAIT;
               end else if (req_s) begin
                  ans_q <= 1'b1;
                  state <= ST_PROBE;
               end
            end
            ST_PROBE: begin
               if (!req_s) begin
                  ans_q <= 1'b0;
                  state <= ST_IDLE;
               end
            end
            ST_CMD_WAIT: begin
               if (req_s && !rd_s) begin
                  if (cnt == '0)
                     cmd_q <= byte_s;
                  else if (cnt == CNT_W'(1))
                     addr_q <= byte_s[ADDR_W-1:0];
                  else
                     wdata_q <= {byte_s, wdata_q[DATA_W-1:BYTE_W]};
                  ans_q <= 1'b1;
                  state <= ST_CMD_HELD;
               end
            end
            ST_CMD_HELD: begin
               if (!req_s) begin
                  ans_q <= 1'b0;
                  if (cnt == CMD_LAST) begin
                     cnt   <= '0;
                     state <= ST_ACCESS;
                  end else begin
                     cnt   <= cnt + 1'b1;
                     state <= ST_CMD_WAIT;
                  end
               end
            end
            ST_ACCESS: begin
               if (is_wr) begin
                  rsp_q <= {ZERO_W, wdata_q};
                  ans_q <= 1'b1;
                  state <= ST_RSP_SHOW;
               end else if (is_rd && (RD_LATENCY != 0)) begin
                  state <= ST_CAPTURE;
               end else if (is_rd) begin
                  rsp_q <= {ZERO_W, rf_rdata};
                  ans_q <= 1'b1;
                  state <= ST_RSP_SHOW;
               end else begin
                  rsp_q <= {BAD_STATUS, ZERO_W};
                  ans_q <= 1'b1;
                  state <= ST_RSP_SHOW;
               end
            end
            ST_CAPTURE: begin
               rsp_q <= {ZERO_W, rf_rdata};
               ans_q <= 1'b1;
               state <= ST_RSP_SHOW;
            end
            ST_RSP_SHOW: begin
               if (req_s) begin
                  ans_q <= 1'b0;
                  state <= ST_RSP_REL;
               end
            end
            ST_RSP_REL: begin
               if (!req_s) begin
                  if (cnt == RSP_LAST) begin
                     busy_q <= 1'b0;
                     state  <= ST_IDLE;
                  end else begin
                     cnt   <= cnt + 1'b1;
                     ans_q <= 1'b1;
                     state <= ST_RSP_SHOW;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign bus_out  = rsp_q[cnt*BYTE_W +: BYTE_W];
   assign bus_oe   = rd_s && ((state == ST_RSP_SHOW) || (state == ST_RSP_REL));
   assign ans_out  = ans_q;
   assign busy_out = busy_q;
   assign rf_stb   = (state == ST_ACCESS) && (is_rd || is_wr);
   assign rf_we    = (state == ST_ACCESS) && is_wr;
   assign rf_addr  = addr_q;
   assign rf_wdata = wdata_q;

endmodule

// File: rtl/hsbus_slave.sv
module hsbus_slave #(
   parameter int                BYTE_W         = 8,
   parameter int                ADDR_W         = 8,
   parameter int                DATA_W         = 32,
   parameter int                SYNC_STAGES    = 2,
   parameter int                RD_LATENCY     = 1,
   parameter logic [BYTE_W-1:0] CMD_READ       = 8'h01,
   parameter logic [BYTE_W-1:0] CMD_WRITE      = 8'h02,
   parameter logic [DATA_W-1:0] BAD_CMD_STATUS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_in,
   input  logic              req_in,
   input  logic              rd_sel_in,
   input  logic [BYTE_W-1:0] bus_in,
   output logic [BYTE_W-1:0] bus_out,
   output logic              bus_oe,
   output logic              ans_out,
   output logic              busy_out,
   output logic              rf_stb,
   output logic              rf_we,
   output logic [ADDR_W-1:0] rf_addr,
   output logic [DATA_W-1:0] rf_wdata,
   input  logic [DATA_W-1:0] rf_rdata
);

   localparam int SYNC_W = BYTE_W + 3;

   generate
      if (DATA_W % BYTE_W != 0) begin : g_bad_word
         $error("DATA_W must be a whole number of bytes");
      end
      if (DATA_W < 2 * BYTE_W) begin : g_bad_short
         $error("DATA_W must span at least two bytes");
      end
      if (ADDR_W > BYTE_W) begin : g_bad_addr
         $error("address must fit in one bus byte");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("at least two synchroniser stages are needed");
      end
      if (RD_LATENCY < 0 || RD_LATENCY > 1) begin : g_bad_lat
         $error("RD_LATENCY must be 0 or 1");
      end
   endgenerate

   logic [SYNC_W-1:0] raw_in;
   logic [SYNC_W-1:0] sync_q;

   assign raw_in = {start_in, req_in, rd_sel_in, bus_in};

   hsbus_sync #(
      .WIDTH  (SYNC_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (sync_q)
   );

   hsbus_engine #(
      .BYTE_W     (BYTE_W),
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .RD_LATENCY (RD_LATENCY),
      .CMD_READ   (CMD_READ),
      .CMD_WRITE  (CMD_WRITE),
      .BAD_STATUS (BAD_CMD_STATUS)
   ) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_s  (sync_q[BYTE_W+2]),
      .req_s    (sync_q[BYTE_W+1]),
      .rd_s     (sync_q[BYTE_W]),
      .byte_s   (sync_q[BYTE_W-1:0]),
      .bus_out  (bus_out),
      .bus_oe   (bus_oe),
      .ans_out  (ans_out),
      .busy_out (busy_out),
      .rf_stb   (rf_stb),
      .rf_we    (rf_we),
      .rf_addr  (rf_addr),
      .rf_wdata (rf_wdata),
      .rf_rdata (rf_rdata)
   );

endmodule

// File: rtl/hsbus_chk.sv
module hsbus_chk #(
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [BYTE_W-1:0] bus_out,
   input logic              bus_oe,
   input logic              ans_out,
   input logic              busy_out,
   input logic              rf_stb
);

   // R6
   oe_in_xact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> busy_out);

   // R6
   oe_not_at_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_stb |-> !bus_oe);

   // R2
   stb_in_xact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_stb |-> (busy_out && !ans_out));

   // R2
   stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_stb |=> !rf_stb);

   // R5
   byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ans_out && $past(ans_out)) |-> $stable(bus_out));

   // R7
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_out) |-> !ans_out);

endmodule

bind hsbus_slave hsbus_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_out  (bus_out),
   .bus_oe   (bus_oe),
   .ans_out  (ans_out),
   .busy_out (busy_out),
   .rf_stb   (rf_stb)
);

// File: tb/hsbus_slave_tb.sv
module hsbus_slave_tb;

   localparam time TCK = 20ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_in = 1'b0;
   logic        req_in = 1'b0;
   logic        rd_sel_in = 1'b0;
   logic [7:0]  bus_in = 8'h00;
   logic [7:0]  bus_out;
   logic        bus_oe;
   logic        ans_out;
   logic        busy_out;
   logic        rf_stb;
   logic        rf_we;
   logic [7:0]  rf_addr;
   logic [31:0] rf_wdata;
   logic [31:0] rf_rdata = 32'h0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] rf_mem [256];
   logic [31:0] shadow [256];
   int          stb_cnt = 0;
   logic        last_we = 1'b0;
   logic [7:0]  last_addr = 8'h00;
   logic [31:0] last_wdata = 32'h0;

   always #(TCK/2) clk = ~clk;

   hsbus_slave u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_in  (start_in),
      .req_in    (req_in),
      .rd_sel_in (rd_sel_in),
      .bus_in    (bus_in),
      .bus_out   (bus_out),
      .bus_oe    (bus_oe),
      .ans_out   (ans_out),
      .busy_out  (busy_out),
      .rf_stb    (rf_stb),
      .rf_we     (rf_we),
      .rf_addr   (rf_addr),
      .rf_wdata  (rf_wdata),
      .rf_rdata  (rf_rdata)
   );

   // register file beside the bench: read data one cycle after the strobe
   always @(posedge clk) begin
      if (rf_stb) begin
         stb_cnt    <= stb_cnt + 1;
         last_we    <= rf_we;
         last_addr  <= rf_addr;
         last_wdata <= rf_wdata;
         if (rf_we) rf_mem[rf_addr] <= rf_wdata;
         else       rf_rdata <= rf_mem[rf_addr];
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_ans(input logic v, input string tag);
      int n = 0;
      while (ans_out !== v && n < 100) begin
         @(negedge clk);
         n++;
      end
      chk(tag, {31'b0, ans_out}, {31'b0, v});
   endtask

   task automatic wr_byte(input logic [7:0] b);
      @(negedge clk);
      rd_sel_in = 1'b0;
      bus_in    = b;
      repeat (3) @(negedge clk);
      chk("R3 no answer before request", {31'b0, ans_out}, 32'h0);
      req_in = 1'b1;
      wait_ans(1'b1, "R3 answer rise");
      chk("R6 oe low in command phase", {31'b0, bus_oe}, 32'h0);
      req_in = 1'b0;
      wait_ans(1'b0, "R3 answer fall");
   endtask

   task automatic rd_byte(output logic [7:0] b);
      @(negedge clk);
      rd_sel_in = 1'b1;
      wait_ans(1'b1, "R5 byte offered");
      repeat (4) @(negedge clk);
      chk("R6 oe high in reply", {31'b0, bus_oe}, 32'h1);
      b = bus_out;
      req_in = 1'b1;
      wait_ans(1'b0, "R5 answer fall");
      req_in = 1'b0;
      @(negedge clk);
   endtask

   task automatic xact(input logic [7:0] cmd, input logic [7:0] addr, input logic [31:0] data,
                       output logic [31:0] d_word, output logic [31:0] s_word);
      logic [7:0] b;
      @(negedge clk);
      start_in = 1'b1;
      repeat (3) @(negedge clk);
      start_in = 1'b0;
      repeat (3) @(negedge clk);
      chk("R7 busy after start", {31'b0, busy_out}, 32'h1);
      wr_byte(cmd);
      wr_byte(addr);
      for (int i = 0; i < 4; i++) wr_byte(data[8*i +: 8]);
      for (int i = 0; i < 4; i++) begin
         rd_byte(b);
         d_word[8*i +: 8] = b;
      end
      for (int i = 0; i < 4; i++) begin
         rd_byte(b);
         s_word[8*i +: 8] = b;
      end
      rd_sel_in = 1'b0;
      repeat (6) @(negedge clk);
      chk("R7 busy released", {31'b0, busy_out}, 32'h0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [31:0] s;
      logic [31:0] v;
      int          base;
      for (int i = 0; i < 256; i++) begin
         rf_mem[i] = 32'h0;
         shadow[i] = 32'h0;
      end
      repeat (5) @(negedge clk);
      chk("R1 answer in reset", {31'b0, ans_out}, 32'h0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 answer after reset", {31'b0, ans_out}, 32'h0);
      chk("R1 busy after reset", {31'b0, busy_out}, 32'h0);
      chk("R1 oe after reset", {31'b0, bus_oe}, 32'h0);
      chk("R1 strobe after reset", {31'b0, rf_stb}, 32'h0);

      // R9 probe without start
      base = stb_cnt;
      req_in = 1'b1;
      wait_ans(1'b1, "R9 probe answer rise");
      chk("R9 probe keeps busy low", {31'b0, busy_out}, 32'h0);
      req_in = 1'b0;
      wait_ans(1'b0, "R9 probe answer fall");
      chk("R9 probe makes no access", stb_cnt - base, 0);

      // write sweep, addresses 0..255 step 17 (R2, R10, R11)
      for (int a = 0; a < 256; a += 17) begin
         v = (a * 32'h0103_0507) ^ 32'hC3A5_96E1;
         base = stb_cnt;
         xact(8'h02, 8'(a), v, d, s);
         chk("R10 write echo data", d, v);
         chk("R10 write status", s, 32'h0);
         chk("R2 one strobe", stb_cnt - base, 1);
         chk("R2 write enable", {31'b0, last_we}, 32'h1);
         chk("R2 address", {24'h0, last_addr}, a);
         chk("R2 write data order", last_wdata, v);
         if (a == 0 || a == 255) chk("R11 edge address", {24'h0, last_addr}, a);
         shadow[a] = v;
      end

      // read sweep, written and neighbouring unwritten addresses (R4, R5)
      for (int a = 0; a < 256; a += 17) begin
         for (int k = 0; k < 2; k++) begin
            int ra = (a + k) % 256;
            base = stb_cnt;
            xact(8'h01, 8'(ra), 32'hFFFF_FFFF, d, s);
            chk("R4 R5 read data word", d, shadow[ra]);
            chk("R4 R5 read status word", s, 32'h0);
            chk("R4 one strobe", stb_cnt - base, 1);
            chk("R4 read enable low", {31'b0, last_we}, 32'h0);
            chk("R4 address", {24'h0, last_addr}, ra);
         end
      end

      // unknown command codes (R8)
      for (int c = 0; c < 48; c++) begin
         if (c == 1 || c == 2) continue;
         base = stb_cnt;
         xact(8'(c), 8'h11, 32'h1234_5678, d, s);
         chk("R8 no access", stb_cnt - base, 0);
         chk("R8 data word zero", d, 32'h0);
         chk("R8 status word", s, 32'h1);
      end
      base = stb_cnt;
      xact(8'hFF, 8'h11, 32'h1234_5678, d, s);
      chk("R8 code FF no access", stb_cnt - base, 0);
      chk("R8 code FF status", s, 32'h1);
      xact(8'h01, 8'h11, 32'h0, d, s);
      chk("R8 register unchanged", d, shadow[17]);

      // reset in the middle of a packet (R1)
      @(negedge clk);
      start_in = 1'b1;
      repeat (3) @(negedge clk);
      start_in = 1'b0;
      repeat (3) @(negedge clk);
      wr_byte(8'h02);
      wr_byte(8'h22);
      rst_n = 1'b0;
      repeat (1000) @(negedge clk);
      chk("R1 mid-packet reset busy", {31'b0, busy_out}, 32'h0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 reset answer low", {31'b0, ans_out}, 32'h0);
      chk("R1 reset busy low", {31'b0, busy_out}, 32'h0);
      xact(8'h01, 8'h00, 32'h0, d, s);
      chk("R1 service after reset", d, shadow[0]);
      chk("R1 status after reset", s, 32'h0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule